// File: doc/BRIEF.md
# Dual-Channel Successive-Approximation Converter Control Logic

This block is the digital half of a two-channel, 10-bit successive-approximation converter that is read over a three-wire serial link. The host pulls the active-low select line to start a conversion. It supplies a serial clock and reads a 16-bit frame. The block drives the track/hold switch and the trial code of an external capacitive DAC. It reads back a single comparator decision per step and picks which of the two analog inputs feeds the sampler.

The level of the serial clock at the moment select falls picks the clock mode. If the clock is low, the host clock paces the whole conversion. If it is high, a divided-down internal tick runs the conversion and the serial clock only reads the result. The search runs two steps past the LSB, so the frame carries two sub-LSB bits. Raising select at any time shuts the block down and abandons the conversion. The select and serial clock inputs are brought into the system clock domain with synchronisers and edge detectors.

Top module: `sar_adc_ctrl`

## Requirements
- R1: At the falling edge of `cs_n`, a high `sclk` selects internal-clock mode: `track`=1 and `dout`=0, which means busy. A low `sclk` selects external-clock mode: `track`=1 and `dout`=1, which is frame bit 1.
- R2: In external mode, tracking continues through the first `sclk` fall and ends at the second. That edge loads trial code 0x800. The third through fourteenth `sclk` falls each resolve one bit of the code, and rising edges leave `dac_code` untouched.
- R3: In internal mode, the first `sclk` fall ends tracking and starts a conversion. The conversion takes one step every `OSC_DIV` system clocks. `dout` stays 0 until the 12 steps finish, then goes to 1 as the end-of-conversion flag. The tick then stops.
- R4: The frame is 16 bits, sent first to last: three ones, the channel-ID bit, D9 down to D0, then S1 and S0. In external mode bit 1 appears when `cs_n` falls. In internal mode it appears at end of conversion. Each later `sclk` fall presents the next bit.
- R5: Every `sclk` fall after bit 16, with `cs_n` still low, drives `dout` to 0.
- R6: `dout_oe` is 0 whenever `cs_n` is high. `dout` changes only after an `sclk` fall, a `cs_n` edge or an end of conversion.
- R7: `ch_sel` is 0 after reset. It toggles at the end of every `cs_n` low period. The channel-ID bit in the frame equals `ch_sel`, so 0 means channel 0 and 1 means channel 1.
- R8: A rising `cs_n` during a conversion clears `track` and `dac_code` and releases `dout`. The next low period starts a fresh conversion.
- R9: The search tests one bit per step, MSB first, starting from 0x800. It keeps the trial bit when `cmp_hi`=1 (input at or above the DAC level) and clears it otherwise. With an ideal comparator, the 12-bit code D9..D0,S1,S0 equals the input level.
- R10: After reset, `dout_oe`=0, `track`=0, `dac_code`=0 and `ch_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Serial clock from the host |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| track | output | 1 | Track/hold switch closed (tracking) |
| dac_code | output | 12 | Trial code for the capacitive DAC |
| ch_sel | output | 1 | Analog input multiplexer select |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial data output enable (0 = high-impedance) |

## Verification
Some properties are checked on every cycle:
- the output is released during shutdown;
- the data line changes only at its legal events;
- the mode-dependent state appears after a select fall;
- the channel toggles per low period;
- trailing zeros follow bit 16;
- the search starts at the MSB and keeps bits the comparator confirms;
- the internal tick stays silent when disabled.

Other behaviour can only be shown by bench scenarios: the complete frame contents against a behavioural comparator, the exact edge at which tracking ends in each mode, the end-of-conversion flag timing, and recovery after an aborted conversion.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic {
    CLK_EXT = 1'b0,
    CLK_INT = 1'b1
  } clk_mode_e;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_t;

endpackage

// File: rtl/sar_edge_sync.sv
module sar_edge_sync
  import sar_ctrl_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  din,
  output edge_t ev
);

  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {(STAGES+1){RST_VAL}};
    else     sh <= {sh[STAGES-1:0], din};
  end

  always_comb begin
    ev.lvl  = sh[STAGES-1];
    ev.rise = sh[STAGES-1] & ~sh[STAGES];
    ev.fall = ~sh[STAGES-1] & sh[STAGES];
  end

endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV-1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_OSC_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick); // R3

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic         step,
  input  logic         cmp,
  output logic [W-1:0] code,
  output logic         last
);

  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
      mask <= '0;
      last <= 1'b0;
    end else begin
      last <= 1'b0;
      if (start) begin
        code <= MSB;
        mask <= MSB;
      end else if (step && (mask != '0)) begin
        code <= (cmp ? code : (code & ~mask)) | (mask >> 1);
        mask <= mask >> 1;
        last <= mask[0];
      end
    end
  end

  AST_SAR_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    (start && !clr) |=> (code == MSB)); // R9

  AST_SAR_KEEP_BIT: assert property (@(posedge clk) disable iff (rst)
    (step && !start && !clr && cmp && (mask != '0)) |=> ((code & $past(mask)) != '0)); // R9

  AST_SAR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (code == '0)); // R8

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int RES     = 10,
  parameter int SUB     = 2,
  parameter int OSC_DIV = 4,
  parameter int SYNC    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 cmp_hi,
  output logic                 track,
  output logic [RES+SUB-1:0]   dac_code,
  output logic                 ch_sel,
  output logic                 dout,
  output logic                 dout_oe
);

  localparam int SAR_W = RES + SUB;
  localparam int LEAD  = 3;
  localparam int FRAME = LEAD + 1 + SAR_W;
  localparam int IDXW  = $clog2(FRAME + 2);

  edge_t cs_e, sk_e;
  clk_mode_e mode;
  logic active, conv, chan, tick, eng_last, eng_start, eng_step, eng_clr, nb;
  logic [IDXW-1:0]  idx, nxt, ridx;
  logic [SAR_W-1:0] code, shv;

  sar_edge_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .din(cs_n), .ev(cs_e));

  sar_edge_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sk_sync (
    .clk(clk), .rst(rst), .din(sclk), .ev(sk_e));

  sar_tick_gen #(.DIV(OSC_DIV)) u_osc (
    .clk(clk), .rst(rst), .en(active && conv && (mode == CLK_INT)), .tick(tick));

  always_comb begin
    eng_clr   = cs_e.rise;
    eng_start = active && !cs_e.rise && sk_e.fall && track &&
                ((mode == CLK_INT) || (idx == IDXW'(LEAD-1)));
    if (mode == CLK_INT)
      eng_step = active && !cs_e.rise && conv && tick;
    else
      eng_step = active && !cs_e.rise && sk_e.fall &&
                 (idx >= IDXW'(LEAD)) && (idx <= IDXW'(LEAD+SAR_W-1));
  end

  sar_engine #(.W(SAR_W)) u_sar (
    .clk(clk), .rst(rst), .clr(eng_clr), .start(eng_start), .step(eng_step),
    .cmp(cmp_hi), .code(code), .last(eng_last));

  // next frame bit, indexed from 1
  always_comb begin
    nxt  = idx + 1'b1;
    ridx = IDXW'(FRAME) - nxt;
    shv  = code >> ridx;
    if (nxt <= IDXW'(LEAD))        nb = 1'b1;
    else if (nxt == IDXW'(LEAD+1)) nb = chan;
    else if (nxt <= IDXW'(FRAME))  nb = shv[0];
    else                           nb = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= CLK_EXT; active <= 1'b0; conv <= 1'b0; chan <= 1'b0;
      idx <= '0; track <= 1'b0; dout <= 1'b0; dout_oe <= 1'b0;
    end else if (cs_e.rise) begin
      if (active) chan <= ~chan;
      active <= 1'b0; conv <= 1'b0; idx <= '0;
      track <= 1'b0; dout <= 1'b0; dout_oe <= 1'b0;
    end else if (cs_e.fall) begin
      active  <= 1'b1;
      conv    <= 1'b0;
      track   <= 1'b1;
      dout_oe <= 1'b1;
      mode    <= sk_e.lvl ? CLK_INT : CLK_EXT;
      idx     <= sk_e.lvl ? IDXW'(0) : IDXW'(1);
      dout    <= ~sk_e.lvl;
    end else if (active) begin
      if (mode == CLK_INT) begin
        if (track && sk_e.fall) begin
          track <= 1'b0;
          conv  <= 1'b1;
        end else if (conv && eng_last) begin
          conv <= 1'b0;
          idx  <= IDXW'(1);
          dout <= 1'b1;
        end else if (!conv && !track && (idx != '0) && sk_e.fall) begin
          if (idx <= IDXW'(FRAME)) idx <= nxt;
          dout <= nb;
        end
      end else if (sk_e.fall) begin
        if (idx == IDXW'(LEAD-1)) track <= 1'b0;
        if (idx <= IDXW'(FRAME)) idx <= nxt;
        dout <= nb;
      end
    end
  end

  assign dac_code = code;
  assign ch_sel   = chan;

  AST_MODE_INT_PICK: assert property (@(posedge clk) disable iff (rst)
    (cs_e.fall && sk_e.lvl) |=> (track && !dout && dout_oe)); // R1
  AST_MODE_EXT_PICK: assert property (@(posedge clk) disable iff (rst)
    (cs_e.fall && !sk_e.lvl) |=> (track && dout && dout_oe)); // R1
  AST_EXT_RISE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sk_e.rise && (mode == CLK_EXT) && !cs_e.rise && !cs_e.fall) |=> $stable(dac_code)); // R2
  AST_TRAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (active && sk_e.fall && !cs_e.rise && !track && !conv && (idx >= IDXW'(FRAME))) |=> !dout); // R5
  AST_HIZ_SHDN: assert property (@(posedge clk) disable iff (rst)
    cs_e.lvl |=> !dout_oe); // R6
  AST_DOUT_EVENTS: assert property (@(posedge clk) disable iff (rst)
    (!sk_e.fall && !cs_e.fall && !cs_e.rise && !eng_last) |=> $stable(dout)); // R6
  AST_CHAN_ALT: assert property (@(posedge clk) disable iff (rst)
    (cs_e.rise && active) |=> (ch_sel != $past(ch_sel))); // R7
  AST_ABORT_TRACK: assert property (@(posedge clk) disable iff (rst)
    cs_e.rise |=> (!track && (dac_code == '0))); // R8

endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic cmp_hi;
  logic track, ch_sel, dout, dout_oe;
  logic [11:0] dac_code;
  logic [11:0] vin = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_ch = 1'b0;

  always #10 clk = ~clk;

  // behavioural comparator: high when input at or above DAC level
  assign cmp_hi = (vin >= dac_code);

  sar_adc_ctrl u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .cmp_hi(cmp_hi),
    .track(track), .dac_code(dac_code), .ch_sel(ch_sel),
    .dout(dout), .dout_oe(dout_oe));

  // {internal mode, input level}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 12'hABC}, {1'b1, 12'h000}, {1'b0, 12'hFFF},
    {1'b1, 12'h555}, {1'b0, 12'h001}, {1'b1, 12'h800}};

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(output logic bit_o);
    sclk = 1'b1; cyc(10);
    sclk = 1'b0; cyc(7);
    bit_o = dout;
    cyc(3);
  endtask

  task automatic run_frame(input logic intm, input logic [11:0] v);
    logic [15:0] got;
    logic b;
    int t;
    vin = v;
    sclk = intm; cyc(10);
    cs_n = 1'b0; cyc(8);
    chk("R1 mode track", 32'(track), 32'd1);
    chk("R1 mode dout", 32'(dout), intm ? 32'd0 : 32'd1);
    if (intm) begin
      sclk = 1'b0; cyc(7);
      chk("R3 track ends at fall 1", 32'(track), 32'd0);
      chk("R3 busy low", 32'(dout), 32'd0);
      cyc(3);
      t = 0;
      while (dout !== 1'b1 && t < 400) begin cyc(1); t++; end
      chk("R3 end of conversion", 32'(dout), 32'd1);
    end
    got[15] = dout;
    for (int k = 1; k < 16; k++) begin
      pulse(b);
      got[15-k] = b;
      if (!intm && k == 1) chk("R2 tracking after fall 1", 32'(track), 32'd1);
      if (!intm && k == 2) chk("R2 tracking ends at fall 2", 32'(track), 32'd0);
    end
    chk("R4 R9 frame", 32'(got), 32'({3'b111, exp_ch, v}));
    chk("R7 channel id", 32'(got[12]), 32'(exp_ch));
    pulse(b); chk("R5 trailing zero 1", 32'(b), 32'd0);
    pulse(b); chk("R5 trailing zero 2", 32'(b), 32'd0);
    cs_n = 1'b1; cyc(8);
    chk("R6 released in shutdown", 32'(dout_oe), 32'd0);
    exp_ch = ~exp_ch;
    chk("R7 ch_sel alternates", 32'(ch_sel), 32'(exp_ch));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic b;
    cyc(4);
    rst = 1'b0;
    cyc(6);
    // R10 reset state
    chk("R10 dout_oe", 32'(dout_oe), 32'd0);
    chk("R10 track", 32'(track), 32'd0);
    chk("R10 dac_code", 32'(dac_code), 32'd0);
    chk("R10 ch_sel", 32'(ch_sel), 32'd0);

    for (int i = 0; i < 6; i++) run_frame(VEC[i][12], VEC[i][11:0]);

    // R8 abort an external-mode conversion mid-search
    vin = 12'h3C3;
    sclk = 1'b0; cyc(10);
    cs_n = 1'b0; cyc(8);
    pulse(b); pulse(b); pulse(b); pulse(b);
    chk("R8 search running", 32'(dac_code != 12'h000), 32'd1);
    cs_n = 1'b1; cyc(8);
    chk("R8 track cleared", 32'(track), 32'd0);
    chk("R8 dac cleared", 32'(dac_code), 32'd0);
    chk("R8 output released", 32'(dout_oe), 32'd0);
    exp_ch = ~exp_ch;
    chk("R7 abort still alternates", 32'(ch_sel), 32'(exp_ch));
    run_frame(1'b0, 12'h3C3);
    run_frame(1'b1, 12'h7FE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule